// File: doc/BRIEF.md
# Sprite Table DMA Engine

This block moves one 256-byte page of CPU memory into the video processor's sprite attribute memory. The CPU starts a copy with one write to a trigger register, and the data byte of that write selects the source page. The engine then holds the CPU in a stall and takes over the system bus. It reads a byte from the page and then writes that byte to the video processor's object-data register. It repeats this read/write pair for every offset from 0 up to 255.

The destination index comes from the video processor's own object address pointer, which advances on each data write. For this reason software clears that pointer before it starts a copy. The engine does not track it. Before the first read the engine waits one cycle. When the trigger landed on an odd cycle it waits one more cycle, so that reads always fall on the same cycle phase. The stall therefore lasts 513 or 514 cycles.

Top module: `sprite_dma`

## Requirements
- R1: While reset is high, and in the first cycle after it, `stall`, `bus_re` and `bus_we` are all low.
- R2: A cycle with `trig_we` high while `stall` is low starts a copy. `stall` is high in the next cycle, and that cycle has no bus access.
- R3: Read number i (i = 0 to 255, in ascending order) drives `bus_re` high and `bus_addr` = {trigger byte, i}. The trigger byte is the upper 8 bits and i is the lower 8 bits.
- R4: Every write drives `bus_we` high with `bus_addr` = OBJ_DATA_ADDR (default 16'h2004). `bus_wdata` equals the `bus_rdata` value returned in the read cycle just before it.
- R5: A copy has exactly 256 reads and 256 writes. Each read is followed at once by its write, and `bus_re` and `bus_we` are never high in the same cycle.
- R6: `stall` stays high for 513 cycles when the trigger cycle is even and 514 cycles when it is odd. The first cycle after reset release is even, and parity alternates on every cycle after that.
- R7: `stall` falls in the cycle after the final write. No bus access occurs while `stall` is low.
- R8: A `trig_we` pulse while `stall` is high is ignored. The source page, the length and the order of the copy do not change, and no second copy follows.
- R9: Reset during a copy aborts it. In the next cycle `stall`, `bus_re` and `bus_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | CPU write strobe for the trigger register |
| trig_data | input | 8 | Written byte, used as the source page |
| bus_addr | output | 16 | Bus master address |
| bus_re | output | 1 | Bus read cycle |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| bus_we | output | 1 | Bus write cycle |
| bus_wdata | output | 8 | Write data |
| stall | output | 1 | Halts the CPU while high |

## Verification
The assertions check the bus discipline on every cycle:
- reads and writes never overlap;
- each read is followed by a write;
- every write goes to the object-data register and carries the byte read just before it;
- bus activity only happens while stalled;
- a stall run never exceeds 514 cycles.

Some behaviour needs whole-transfer scenarios from the bench:
- the exact 513 or 514 cycle length, which depends on trigger parity;
- the ascending source addresses taken from the trigger byte;
- that busy-time triggers are ignored;
- that reset aborts a copy mid-way.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_ALIGN = 3'd2,
    ST_READ  = 3'd3,
    ST_WRITE = 3'd4
  } dma_state_t;

endpackage

// File: rtl/sprite_dma_phase.sv
module sprite_dma_phase (
  input  logic clk,
  input  logic rst,
  output logic odd
);

  // Cycle parity: even in the first cycle after reset, then alternating.
  always_ff @(posedge clk) begin
    if (rst) odd <= 1'b0;
    else     odd <= ~odd;
  end

endmodule

// File: rtl/sprite_dma_seq.sv
module sprite_dma_seq
  import sprite_dma_pkg::*;
#(
  parameter int XFER_LEN = 256,
  parameter int PAGE_W   = 8,
  localparam int IDX_W   = $clog2(XFER_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_we,
  input  logic [PAGE_W-1:0] trig_page,
  input  logic              odd,
  output dma_state_t        state_q,
  output dma_state_t        state_d,
  output logic [IDX_W-1:0]  idx_d,
  output logic [PAGE_W-1:0] page_d
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;
  logic              odd_q;
  logic              odd_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    page_d  = page_q;
    odd_d   = odd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (trig_we) begin
          state_d = ST_WAIT;
          page_d  = trig_page;
          idx_d   = '0;
          odd_d   = odd;
        end
      end
      ST_WAIT:  state_d = odd_q ? ST_ALIGN : ST_READ;
      ST_ALIGN: state_d = ST_READ;
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: begin
        if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_READ;
          idx_d   = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      page_q  <= '0;
      odd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      page_q  <= page_d;
      odd_q   <= odd_d;
    end
  end

endmodule

// File: rtl/sprite_dma_bus.sv
module sprite_dma_bus
  import sprite_dma_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              DATA_W        = 8,
  parameter int              IDX_W         = 8,
  parameter logic [ADDR_W-1:0] OBJ_DATA_ADDR = 16'h2004,
  localparam int             PAGE_W        = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dma_state_t        state_q,
  input  dma_state_t        state_d,
  input  logic [IDX_W-1:0]  idx_d,
  input  logic [PAGE_W-1:0] page_d,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_re,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              stall
);

  // Outputs are registered from the next state, so they line up with state_q.
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_addr  <= '0;
      bus_re    <= 1'b0;
      bus_we    <= 1'b0;
      bus_wdata <= '0;
      stall     <= 1'b0;
    end else begin
      stall  <= (state_d != ST_IDLE);
      bus_re <= (state_d == ST_READ);
      bus_we <= (state_d == ST_WRITE);
      unique case (state_d)
        ST_READ:  bus_addr <= {page_d, idx_d};
        ST_WRITE: bus_addr <= OBJ_DATA_ADDR;
        default:  bus_addr <= '0;
      endcase
      // Latch the byte returned during the read cycle for the following write.
      if (state_q == ST_READ) bus_wdata <= bus_rdata;
    end
  end

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
  import sprite_dma_pkg::*;
#(
  parameter int              ADDR_W        = 16,
  parameter int              DATA_W        = 8,
  parameter int              XFER_LEN      = 256,
  parameter logic [ADDR_W-1:0] OBJ_DATA_ADDR = 16'h2004,
  localparam int             IDX_W         = $clog2(XFER_LEN),
  localparam int             PAGE_W        = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_we,
  input  logic [DATA_W-1:0] trig_data,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              stall
);

  logic              odd;
  dma_state_t        state_q;
  dma_state_t        state_d;
  logic [IDX_W-1:0]  idx_d;
  logic [PAGE_W-1:0] page_d;

  sprite_dma_phase u_phase (
    .clk (clk),
    .rst (rst),
    .odd (odd)
  );

  sprite_dma_seq #(
    .XFER_LEN (XFER_LEN),
    .PAGE_W   (PAGE_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .trig_we   (trig_we),
    .trig_page (trig_data[PAGE_W-1:0]),
    .odd       (odd),
    .state_q   (state_q),
    .state_d   (state_d),
    .idx_d     (idx_d),
    .page_d    (page_d)
  );

  sprite_dma_bus #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .IDX_W         (IDX_W),
    .OBJ_DATA_ADDR (OBJ_DATA_ADDR)
  ) u_bus (
    .clk       (clk),
    .rst       (rst),
    .state_q   (state_q),
    .state_d   (state_d),
    .idx_d     (idx_d),
    .page_d    (page_d),
    .bus_rdata (bus_rdata),
    .bus_addr  (bus_addr),
    .bus_re    (bus_re),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .stall     (stall)
  );

endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
  parameter int              ADDR_W        = 16,
  parameter int              DATA_W        = 8,
  parameter logic [ADDR_W-1:0] OBJ_DATA_ADDR = 16'h2004
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              stall
);

  logic [10:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)        run_len <= '0;
    else if (stall) run_len <= run_len + 1'b1;
    else            run_len <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!stall && !bus_re && !bus_we)); // R1
  AST_START_BY_TRIG: assert property (@(posedge clk) disable iff (rst) $rose(stall) |-> $past(trig_we)); // R2
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (rst) bus_we |-> (bus_addr == OBJ_DATA_ADDR)); // R4
  AST_DATA_FORWARD: assert property (@(posedge clk) disable iff (rst) bus_we |-> (bus_wdata == $past(bus_rdata))); // R4
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (rst) bus_re |=> bus_we); // R5
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst) !(bus_re && bus_we)); // R5
  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst) stall |-> (run_len < 11'd514)); // R6
  AST_BUS_IDLE_FREE: assert property (@(posedge clk) disable iff (rst) (bus_re || bus_we) |-> stall); // R7

endmodule

bind sprite_dma sprite_dma_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .OBJ_DATA_ADDR (OBJ_DATA_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_we   (trig_we),
  .bus_addr  (bus_addr),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .stall     (stall)
);

// File: tb/test_sprite_dma.sv
module test_sprite_dma;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_we = 1'b0;
  logic [7:0]  trig_data = 8'h00;
  logic [15:0] bus_addr;
  logic        bus_re;
  logic [7:0]  bus_rdata;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic        stall;
  bit          bp;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  // Bench parity per R6: even in first cycle after reset, then alternating.
  always @(posedge clk) bp <= rst ? 1'b0 : ~bp;

  function automatic logic [7:0] mem_model(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] + 8'h3C);
  endfunction

  assign bus_rdata = bus_re ? mem_model(bus_addr) : 8'h00;

  sprite_dma i_sprite_dma (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_data(trig_data),
    .bus_addr(bus_addr), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Vector: {page[7:0], trigger parity, expected stall length[9:0]}
  localparam logic [18:0] VECS [5] = '{
    {8'h02, 1'b0, 10'd513},
    {8'h07, 1'b1, 10'd514},
    {8'h00, 1'b0, 10'd513},
    {8'hFF, 1'b1, 10'd514},
    {8'h80, 1'b0, 10'd513}
  };

  task automatic run_dma(input logic [7:0] page, input bit want_odd,
                         input int exp_len, input bit inject);
    int len = 0, rd = 0, wr = 0, aerr = 0, derr = 0, oerr = 0;
    logic [7:0] expd = 8'h00;
    bit prev_re = 1'b0, last_we = 1'b0, first_quiet;
    while (bp != want_odd) @(negedge clk);
    trig_data = page;
    trig_we   = 1'b1;
    @(negedge clk);
    trig_we   = 1'b0;
    first_quiet = stall && !bus_re && !bus_we;
    check(first_quiet, "R2 start cycle", int'(stall), 1);
    while (stall && len < 700) begin
      len++;
      if (bus_re && bus_we) oerr++;
      if (bus_re) begin
        if (bus_addr != {page, rd[7:0]}) aerr++;
        expd = mem_model(bus_addr);
        rd++;
      end
      if (bus_we) begin
        if (bus_addr != 16'h2004 || bus_wdata != expd || !prev_re) derr++;
        wr++;
      end
      prev_re = bus_re;
      last_we = bus_we;
      if (inject && len == 100) begin
        trig_data = 8'hAA;
        trig_we   = 1'b1;
      end else begin
        trig_we = 1'b0;
      end
      @(negedge clk);
    end
    trig_we = 1'b0;
    check(len == exp_len, "R6 stall length", len, exp_len);
    check(aerr == 0, "R3 source addresses", aerr, 0);
    check(derr == 0, "R4 write target/data", derr, 0);
    check(rd == 256 && wr == 256 && oerr == 0, "R5 pair count", rd + wr, 512);
    check(last_we && !bus_re && !bus_we, "R7 stall drop after final write",
          int'(last_we), 1);
    if (inject) begin
      repeat (3) begin
        @(negedge clk);
        check(!stall && !bus_re && !bus_we, "R8 no second copy", int'(stall), 0);
      end
    end
  endtask

  initial begin
    fork
      begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (3) @(negedge clk);
    check(!stall && !bus_re && !bus_we, "R1 reset state", int'(stall), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!stall && !bus_re && !bus_we, "R1 first cycle after reset", int'(stall), 0);

    for (int i = 0; i < 5; i++) begin
      run_dma(VECS[i][18:11], VECS[i][10], int'(VECS[i][9:0]), 1'b0);
      @(negedge clk);
    end

    // R8: trigger while busy is ignored
    run_dma(8'h33, 1'b1, 514, 1'b1);

    // R9: reset mid-transfer aborts
    while (bp != 1'b0) @(negedge clk);
    trig_data = 8'h44;
    trig_we   = 1'b1;
    @(negedge clk);
    trig_we = 1'b0;
    repeat (50) @(negedge clk);
    check(stall, "R9 busy before abort", int'(stall), 1);
    rst = 1'b1;
    @(negedge clk);
    check(!stall && !bus_re && !bus_we, "R9 abort by reset", int'(stall), 0);
    rst = 1'b0;

    // R6: first cycle after reset release counts as even
    trig_data = 8'h10;
    run_dma(8'h10, 1'b0, 513, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule